// File: doc/BRIEF.md
# Edge Timetagger with Per-Edge Enables

The block watches four asynchronous digital lines and turns their transitions into 64-bit event words. Each line is first brought into the clock domain. A level change is then found by comparing the newest sample with the sample one cycle older. A free-running cycle counter supplies the timestamp, so the time resolution is one period of the sample clock.

The rising and falling transitions of every line each have their own enable bit. All transitions that are enabled and land in the same cycle are folded into a single word. That word carries the timestamp and two masks, one for lines that rose and one for lines that fell. A global enable switches event creation on and off.

Words leave through a valid/ready handshake. A small FIFO holds them while the consumer stalls. If an event arrives while the FIFO is full, the event is lost and a sticky overflow flag is raised.

Top module: `edge_timetagger`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `evt_valid_o` and `overflow_o` are 0.
- R2: A rising edge on line i with `edge_en_i[i]` set produces a word with bit 48+i set. The word layout is tag 8'hE7 in bits 63:56, falling mask in 55:52, rising mask in 51:48 and timestamp in 47:0. If the input changes between clock edges n and n+1 (edges counted from 1 after reset release), the timestamp is n+2.
- R3: A falling edge on line i with `edge_en_i[4+i]` set produces a word with bit 52+i set, using the same timestamp rule.
- R4: All enabled edges detected in the same cycle appear in one word, with both masks filled.
- R5: An edge whose enable bit is 0 creates no word and reads as 0 in the masks of any word it coincides with.
- R6: While `enable_i` is 0, no word is created and `overflow_o` is cleared.
- R7: While `evt_ready_i` is 0, up to FIFO_DEPTH (default 4) words are held and later delivered in order of creation.
- R8: A word created while the FIFO holds FIFO_DEPTH words is dropped and sets `overflow_o`, which stays set while `enable_i` is 1.
- R9: The timestamp counter advances by one every cycle whether or not events occur, so the timestamps of two words differ by the number of cycles between their edges.
- R10: While `evt_valid_o` is 1 and `evt_ready_i` is 0, valid stays 1 and `evt_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 4 | Asynchronous digital lines |
| edge_en_i | input | 8 | Bits 3:0 enable rising edges, bits 7:4 enable falling edges, one bit per line |
| enable_i | input | 1 | Global event enable |
| evt_data_o | output | 64 | Event word |
| evt_valid_o | output | 1 | Event word available |
| evt_ready_i | input | 1 | Consumer accepts the word |
| overflow_o | output | 1 | Sticky flag: an event was lost |

## Verification
A wrong previous-sample register or synchronizer depth shows up as a timestamp that is off by a fixed number of cycles. It also shows up as a spurious or missing word, visible three cycles after the input change. A broken FIFO pointer or count shows up as reordered, repeated or lost words once the consumer releases a stall. It can also show as an overflow flag raised before the FIFO is really full. Wrong mask gating shows up as stray mask bits for disabled edges in the very next word that is delivered.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned TS_W  = 48;
  localparam int unsigned TAG_W = 8;
  localparam logic [TAG_W-1:0] EVT_TAG = 8'hE7;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [N_CH-1:0]  fall;
    logic [N_CH-1:0]  rise;
    logic [TS_W-1:0]  ts;
  } evt_t;

  localparam int unsigned EVT_W = $bits(evt_t);
endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= stg_q[STAGES-1];
  end

  assign cur_o = stg_q[STAGES-1];
endmodule

// File: rtl/tt_stamp.sv
module tt_stamp #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/tt_event_former.sv
module tt_event_former
  import tt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] cur_i,
  input  logic [N_CH-1:0] prev_i,
  input  logic [N_CH-1:0] rise_en_i,
  input  logic [N_CH-1:0] fall_en_i,
  input  logic            enable_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            fire_o,
  output evt_t            evt_o
);
  logic [N_CH-1:0] rise, fall;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign rise[c] = cur_i[c] & ~prev_i[c] & rise_en_i[c];
    assign fall[c] = ~cur_i[c] & prev_i[c] & fall_en_i[c];
  end

  always_comb begin
    evt_o.tag  = EVT_TAG;
    evt_o.fall = fall;
    evt_o.rise = rise;
    evt_o.ts   = ts_i;
    fire_o     = enable_i & (|{rise, fall});
  end

  // R4: a word never goes out with empty masks
  a_r4_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> ((evt_o.rise | evt_o.fall) != '0));
  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !fire_o);
endmodule

// File: rtl/tt_fifo.sv
module tt_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rptr_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = valid_o & ready_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/edge_timetagger.sv
module edge_timetagger
  import tt_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   sig_i,
  input  logic [2*N_CH-1:0] edge_en_i,
  input  logic              enable_i,
  output logic [EVT_W-1:0]  evt_data_o,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic              overflow_o
);
  logic [N_CH-1:0] cur, prev;
  logic [TS_W-1:0] ts;
  logic            fire, full;
  evt_t            evt;

  tt_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sig_i), .cur_o(cur), .prev_o(prev));

  tt_stamp #(.W(TS_W)) u_stamp (.clk_i(clk_i), .rst_ni(rst_ni), .ts_o(ts));

  tt_event_former u_form (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(cur), .prev_i(prev),
    .rise_en_i(edge_en_i[N_CH-1:0]), .fall_en_i(edge_en_i[2*N_CH-1:N_CH]),
    .enable_i(enable_i), .ts_i(ts), .fire_o(fire), .evt_o(evt));

  tt_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(fire), .data_i(evt),
    .full_o(full), .valid_o(evt_valid_o), .data_o(evt_data_o), .ready_i(evt_ready_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            overflow_o <= 1'b0;
    else if (!enable_i)     overflow_o <= 1'b0;
    else if (fire && full)  overflow_o <= 1'b1;
  end

  a_r8_drop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && full) |=> overflow_o);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && enable_i) |=> overflow_o);
endmodule

// File: tb/edge_timetagger_test.sv
module edge_timetagger_test;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_ni = 0;
  logic [3:0]  sig = '0;
  logic [7:0]  en  = 8'hFF;
  logic        ena = 0, rdy = 1;
  logic [63:0] data;
  logic        valid, ovf;

  edge_timetagger #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig), .edge_en_i(en), .enable_i(ena),
    .evt_data_o(data), .evt_valid_o(valid), .evt_ready_i(rdy), .overflow_o(ovf));

  always #5 clk = ~clk;

  int           checks = 0, errors = 0;
  longint       cyc = 0;
  logic [63:0]  expq[$];
  string        tagq[$];
  bit           done = 0;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && valid && rdy) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual unexpected word %h expected none", data);
      end else begin
        string t;
        logic [63:0] e;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, data, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // driver: change lines just after an edge, predict the word
  task automatic drive(input logic [3:0] v, input bit keep, input string req);
    logic [3:0] r, f;
    step(1);
    r = v & ~sig & en[3:0];
    f = ~v & sig & en[7:4];
    if (ena && ((r | f) != 0) && keep) begin
      expq.push_back({8'hE7, f, r, 48'(cyc + 2)});
      tagq.push_back(req);
    end
    sig = v;
  endtask

  task automatic drain;
    for (int i = 0; i < 60 && expq.size() != 0; i++) step(1);
    step(2);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] held;
    step(3);
    chk("R1 valid in reset", {63'b0, valid}, 64'd0);
    chk("R1 overflow in reset", {63'b0, ovf}, 64'd0);
    rst_ni = 1;
    step(3);
    chk("R1 valid after reset", {63'b0, valid}, 64'd0);
    chk("R1 overflow after reset", {63'b0, ovf}, 64'd0);
    ena = 1;

    drive(4'b0001, 1, "R2 rise ch0"); step(4);
    drive(4'b1001, 1, "R2 rise ch3"); step(4);
    drive(4'b1000, 1, "R3 fall ch0"); step(4);
    drive(4'b0110, 1, "R4 merged rise+fall"); step(4);
    drive(4'b0111, 1, "R9 first"); step(7);
    drive(4'b0110, 1, "R9 second"); step(11);
    drive(4'b0111, 1, "R9 third"); step(4);
    drain();
    chk("R2 all words delivered", 64'(expq.size()), 64'd0);

    // R5: rising edges of ch3 disabled, falling of ch1 disabled
    en = 8'b1101_0111;
    drive(4'b1111, 1, "R5 disabled rise"); step(6);
    chk("R5 no word for disabled edge", {63'b0, valid}, 64'd0);
    drive(4'b1101, 1, "R5 disabled fall"); step(6);
    chk("R5 no word for disabled fall", {63'b0, valid}, 64'd0);
    drive(4'b0100, 1, "R5 masked merge"); step(4);
    drive(4'b1001, 1, "R5 masked merge 2"); step(4);
    drain();
    en = 8'hFF;

    // R6: global disable
    ena = 0;
    drive(4'b0110, 1, "R6"); step(6);
    chk("R6 no word while disabled", {63'b0, valid}, 64'd0);
    ena = 1;
    step(4);
    chk("R6 no late word after enable", {63'b0, valid}, 64'd0);

    // R7 / R10: stall
    rdy = 0;
    drive(4'b0111, 1, "R7 order 1"); step(2);
    drive(4'b0011, 1, "R7 order 2"); step(2);
    drive(4'b1011, 1, "R7 order 3"); step(4);
    @(negedge clk);
    held = data;
    chk("R10 valid while stalled", {63'b0, valid}, 64'd1);
    repeat (5) @(negedge clk);
    chk("R10 valid held", {63'b0, valid}, 64'd1);
    chk("R10 data held", data, held);
    step(1);
    rdy = 1;
    drain();
    chk("R7 all stalled words delivered", 64'(expq.size()), 64'd0);

    // R8: overflow
    rdy = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      drive(sig ^ 4'b0001, (i < DEPTH), "R8 kept");
      step(2);
    end
    step(4);
    chk("R8 overflow set", {63'b0, ovf}, 64'd1);
    rdy = 1;
    drain();
    chk("R8 only DEPTH words kept", 64'(expq.size()), 64'd0);
    chk("R8 overflow sticky", {63'b0, ovf}, 64'd1);
    ena = 0;
    step(2);
    chk("R6 overflow cleared by disable", {63'b0, ovf}, 64'd0);
    ena = 1;
    step(3);
    chk("R1 idle at end", {63'b0, valid}, 64'd0);

    done = 1;
    finish_run();
  end
endmodule